// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. A cycle with the advance strobe low and the select input high captures a new external address. The upper bits are kept as they are. The two lowest bits become the burst start. Each later cycle with the strobe high moves the burst one beat forward. The generated low bits return to the start value after the fourth beat.

A static order input sets how the low bits run through the burst. With the order input low, the bits count upward modulo four. With it high, each beat's low bits are the start XOR the beat number. A hold input freezes the whole block, so a memory controller can stall for as many cycles as it needs. A load cycle with select low ends the burst. After that, strobe-high cycles produce no valid address until a new load.

Top module: `burst_addr_seq`

## Requirements
- R1: With `order_i` = 0 (linear), the low two bits of `addr_o` equal (start + `beat_o`) modulo 4.
- R2: With `order_i` = 1 (interleaved), the low two bits of `addr_o` equal start XOR `beat_o`. For example, start 01 gives 01, 00, 11, 10.
- R3: A cycle with `hold_i`=0, `adv_i`=0 and `sel_i`=1 captures `addr_i`. After that edge, `addr_o` equals `addr_i`, `beat_o` is 0 and `valid_o` is 1.
- R4: A cycle with `hold_i`=0, `adv_i`=1 and an active burst increments `beat_o` by one, modulo 4. After four advances the address is back at the start value. `sel_i` is ignored during advance cycles.
- R5: While `hold_i`=1, `addr_o`, `beat_o` and `valid_o` keep their values, whatever `adv_i`, `sel_i` and `addr_i` do.
- R6: The upper bits of `addr_o` (all but bits 1:0) stay at the loaded value for the whole burst.
- R7: A cycle with `hold_i`=0, `adv_i`=0 and `sel_i`=0 is a deselect. `valid_o` is 0 after it, and later advance cycles leave `valid_o` at 0 until the next load.
- R8: After reset, `valid_o` is 0, `beat_o` is 0 and `addr_o` is 0. An advance before any load leaves `valid_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | High: freeze all state this cycle |
| adv_i | input | 1 | Low: load or deselect; high: advance one beat |
| sel_i | input | 1 | With adv_i low: 1 loads, 0 deselects |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address captured on a load |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index within the burst |
| valid_o | output | 1 | A burst is active and addr_o is meaningful |

## Verification
Every result is set at the rising edge that samples the command. The state registers update at that edge, and the outputs are combinational decodes of them. A load, advance, hold or deselect therefore shows on the outputs one cycle after the command is presented. The bench drives each command on the falling edge. It waits for the next rising edge and samples 1 ns later, before the next command is driven. Each vector row pairs one command with the outputs expected at that single sampling point.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LOW_W  = 2;
    localparam int BEAT_W = 2;

    typedef logic [LOW_W-1:0]  low_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_DESEL,
        CMD_STEP
    } cmd_e;

    function automatic low_t burst_low(input low_t start, input beat_t beat, input order_e ord);
        low_t res;
        if (ord == ORD_INTERLEAVE) res = start ^ low_t'(beat);
        else                       res = start + low_t'(beat);
        return res;
    endfunction

    function automatic cmd_e decode_cmd(input logic hold, input logic adv,
                                        input logic sel, input logic active);
        cmd_e c;
        if (hold)         c = CMD_IDLE;
        else if (!adv)    c = sel ? CMD_LOAD : CMD_DESEL;
        else if (active)  c = CMD_STEP;
        else              c = CMD_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg
    import burst_seq_pkg::*;
#(
    parameter int UP_W = 17
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  logic            hold,
    input  logic [UP_W-1:0] upper_in,
    input  low_t            start_in,
    output logic [UP_W-1:0] upper_q,
    output low_t            start_q,
    output logic            active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q  <= '0;
            start_q  <= '0;
            active_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    upper_q  <= upper_in;
                    start_q  <= start_in;
                    active_q <= 1'b1;
                end
                CMD_DESEL: active_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> $stable(upper_q) && $stable(start_q));

    assert_desel_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_DESEL) |=> !active_q);

    assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(upper_q) && $stable(start_q) && $stable(active_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_e  cmd,
    input  logic  hold,
    output beat_t beat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: beat_q <= '0;
                CMD_STEP: beat_q <= beat_q + beat_t'(1);
                default: ;
            endcase
        end
    end

    assert_load_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (beat_q == '0));

    assert_step_inc_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (beat_q == $past(beat_q) + beat_t'(1)));

    assert_hold_beat_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(beat_q));

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
    import burst_seq_pkg::*;
(
    input  low_t   start,
    input  beat_t  beat,
    input  order_e ord,
    output low_t   low
);

    always_comb begin
        low = burst_low(start, beat, ord);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              adv_i,
    input  logic              sel_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o,
    output logic              valid_o
);

    localparam int UP_W = ADDR_W - LOW_W;

    cmd_e            cmd;
    logic [UP_W-1:0] upper_q;
    low_t            start_q;
    logic            active_q;
    beat_t           beat_q;
    low_t            low;
    order_e          ord;

    always_comb begin
        cmd = decode_cmd(hold_i, adv_i, sel_i, active_q);
        ord = order_e'(order_i);
    end

    burst_load_reg #(.UP_W(UP_W)) u_load (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .hold     (hold_i),
        .upper_in (addr_i[ADDR_W-1:LOW_W]),
        .start_in (addr_i[LOW_W-1:0]),
        .upper_q  (upper_q),
        .start_q  (start_q),
        .active_q (active_q)
    );

    burst_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .hold   (hold_i),
        .beat_q (beat_q)
    );

    burst_order_gen u_order (
        .start (start_q),
        .beat  (beat_q),
        .ord   (ord),
        .low   (low)
    );

    assign addr_o  = {upper_q, low};
    assign beat_o  = beat_q;
    assign valid_o = active_q;

    assert_linear_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i && valid_o && !order_i) ##1 !order_i
        |-> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);

    assert_interleave_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i && valid_o && order_i) ##1 order_i
        |-> (addr_o[1:0] ^ $past(addr_o[1:0])) == (beat_o ^ $past(beat_o)));

    assert_load_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !adv_i && sel_i) |=> valid_o && (addr_o == $past(addr_i)));

    assert_idle_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && adv_i) |=> !valid_o);

endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int AW = 19;
    localparam int NV = 21;
    // {hold, adv, sel, order, addr_in[18:0], exp_valid, exp_beat[1:0], exp_addr[18:0]}
    localparam logic [44:0] VEC [NV] = '{
        {4'b0010, 19'h12345, 1'b1, 2'd0, 19'h12345},
        {4'b0110, 19'h00000, 1'b1, 2'd1, 19'h12346},
        {4'b0100, 19'h00000, 1'b1, 2'd2, 19'h12347},
        {4'b0110, 19'h00000, 1'b1, 2'd3, 19'h12344},
        {4'b0110, 19'h00000, 1'b1, 2'd0, 19'h12345},
        {4'b0011, 19'h0ABC1, 1'b1, 2'd0, 19'h0ABC1},
        {4'b0111, 19'h00000, 1'b1, 2'd1, 19'h0ABC0},
        {4'b0111, 19'h00000, 1'b1, 2'd2, 19'h0ABC3},
        {4'b0111, 19'h00000, 1'b1, 2'd3, 19'h0ABC2},
        {4'b1111, 19'h7FFFF, 1'b1, 2'd3, 19'h0ABC2},
        {4'b1011, 19'h7FFFF, 1'b1, 2'd3, 19'h0ABC2},
        {4'b0111, 19'h00000, 1'b1, 2'd0, 19'h0ABC1},
        {4'b0000, 19'h00000, 1'b0, 2'd0, 19'h00000},
        {4'b0110, 19'h00000, 1'b0, 2'd0, 19'h00000},
        {4'b0010, 19'h40003, 1'b1, 2'd0, 19'h40003},
        {4'b0110, 19'h00000, 1'b1, 2'd1, 19'h40000},
        {4'b0011, 19'h00002, 1'b1, 2'd0, 19'h00002},
        {4'b0111, 19'h00000, 1'b1, 2'd1, 19'h00003},
        {4'b0111, 19'h00000, 1'b1, 2'd2, 19'h00000},
        {4'b0111, 19'h00000, 1'b1, 2'd3, 19'h00001},
        {4'b1001, 19'h00000, 1'b1, 2'd3, 19'h00001}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          sel_i = 1'b0;
    logic          order_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;
    logic          valid_o;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .hold_i(hold_i), .adv_i(adv_i), .sel_i(sel_i),
        .order_i(order_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o),
        .valid_o(valid_o)
    );

    task automatic check(input string req, input logic v, input logic [1:0] b,
                         input logic [AW-1:0] a, input logic chk_addr);
        n_run++;
        if (valid_o !== v || (chk_addr && (beat_o !== b || addr_o !== a))) begin
            n_fail++;
            $display("FAIL %s: valid=%0b beat=%0d addr=%05h expected valid=%0b beat=%0d addr=%05h",
                     req, valid_o, beat_o, addr_o, v, b, a);
        end
    endtask

    task automatic apply(input logic [3:0] ctl, input logic [AW-1:0] a);
        @(negedge clk);
        {hold_i, adv_i, sel_i, order_i} = ctl;
        addr_i = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        check("R8 reset", 1'b0, 2'd0, '0, 1'b1);
        // R8: advance before any load stays invalid
        apply(4'b0110, 19'h11111);
        check("R8 idle advance", 1'b0, 2'd0, '0, 1'b1);
        // R3/R1/R2/R4/R5/R6/R7 through the vector table
        for (int i = 0; i < NV; i++) begin
            logic [44:0] e;
            e = VEC[i];
            apply(e[44:41], e[40:22]);
            check($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R7)", i),
                  e[21], e[20:19], e[18:0], e[21]);
        end
        // R5: hold survives a deselect attempt and a reload attempt
        apply(4'b1000, 19'h00000);
        check("R5 hold desel", 1'b1, 2'd3, 19'h00001, 1'b1);
        // R7: deselect then repeated advances stay invalid
        apply(4'b0000, 19'h00000);
        apply(4'b0100, 19'h00000);
        apply(4'b0100, 19'h00000);
        check("R7 advance after deselect", 1'b0, 2'd0, '0, 1'b0);
        // R6: top address bits all ones, wrap in low bits only
        apply(4'b0010, 19'h7FFFF);
        check("R6 load top", 1'b1, 2'd0, 19'h7FFFF, 1'b1);
        apply(4'b0110, 19'h00000);
        check("R6 upper kept", 1'b1, 2'd1, 19'h7FFFC, 1'b1);
        // R8: reset mid-burst
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R8 reset mid-burst", 1'b0, 2'd0, '0, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule